// File: doc/BRIEF.md
# Reset and Clock Output Controller

This block drives the reset and clock pins of an optical-drive decoder. When the host writes the soft-reset command code 08h into the packet command register, the block pulls the local CPU reset output low for a fixed number of crystal-clock cycles. It also raises an interrupt to the local microcontroller at the same moment. The chip's own reset is copied straight onto that CPU reset output. A second open-drain output resets the system. It is pulled low either by a microcontroller register bit or by the host reset pin.

Two master-clock outputs are also produced. Each one carries the crystal clock, a divided copy of it, or a constant low level. The select for each output is a register field. A new select takes hold only while the divided clock is low, so no shortened pulse appears on the pin. The microcontroller's chip select has a polarity chosen by a strap input.

Because the pulse width is a count of crystal cycles, the pulse lasts about 1 ms with a 33.8688 MHz crystal and about 2 ms with a 16.9344 MHz crystal. Both reset outputs are open-drain: the block only produces the enable that pulls each pin low.

Top module: `rst_clk_out_ctrl`

## Requirements
- R1: A host command write (host_cmd_we_i high) with code 8'h08 asserts cpu_rst_oe_o from the next rising clock edge for exactly 2^PULSE_W clock cycles.
- R2: A host command write with any code other than 8'h08 has no effect on cpu_rst_oe_o or mcu_irq_o.
- R3: mcu_irq_o is set on the same edge that starts the pulse. It then holds until a selected microcontroller write to CLR_ADDR with data bit 0 set. If a set and a clear arrive in the same cycle, the set wins.
- R4: While rst_ni is low, cpu_rst_oe_o is high at once, with no clock needed and whether or not a pulse is running. Reset also cancels any pulse in progress.
- R5: sys_rst_oe_o is high when control register bit 7 (at CTRL_ADDR) holds 0, or when host_rst_ni is low. Otherwise it is low.
- R6: A microcontroller write is accepted only while the chip select is active. When cs_pol_i is 1, the select is active for mcu_cs_i = 0. When cs_pol_i is 0, the select is active for mcu_cs_i = 1.
- R7: The mck_o select is control bits [1:0]. The code 00 passes clk_i, 01 gives clk_i/2^MCK_DIV_W (default /2), and 10 or 11 holds the output low.
- R8: The mck2_o select is control bits [3:2]. It uses the same codes, with a divide of clk_i/2^MCK2_DIV_W (default /512).
- R9: A select change takes effect only while that output's divided clock is low. A divided high phase that is already running finishes at its full length.
- R10: A soft-reset command that arrives during a pulse restarts the count, so the pulse ends 2^PULSE_W cycles after the last command.
- R11: After reset, cpu_rst_oe_o, sys_rst_oe_o and mcu_irq_o are 0, and both clock outputs pass clk_i undivided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Chip reset, active low, asynchronous |
| host_rst_ni | input | 1 | Host reset pin, active low |
| host_cmd_we_i | input | 1 | Host write strobe for the command register |
| host_cmd_i | input | 8 | Host command code |
| cs_pol_i | input | 1 | Chip-select polarity strap (1: active low) |
| mcu_cs_i | input | 1 | Microcontroller chip select |
| mcu_we_i | input | 1 | Microcontroller write strobe |
| mcu_addr_i | input | ADDR_W | Microcontroller register address |
| mcu_wdata_i | input | 8 | Microcontroller write data |
| cpu_rst_oe_o | output | 1 | Pull-low enable for the CPU reset pin |
| sys_rst_oe_o | output | 1 | Pull-low enable for the system reset pin |
| mcu_irq_o | output | 1 | Soft-reset interrupt to the microcontroller |
| mck_o | output | 1 | Master clock output 1 |
| mck2_o | output | 1 | Master clock output 2 |

## Verification
The bench measures the pulse to the exact cycle. A counter off by one would lengthen or shorten it, and a design that ignored a second command would end the pulse early. The bench also delivers an interrupt clear on the same cycle as a new command; a design that let the clear win would lose the interrupt. It switches the /512 output to stopped in the middle of a high phase. A design that applied the select at once would cut that phase short of 256 cycles. Chip reset is asserted between clock edges during a pulse, which catches a design that copies reset only through a register.

// File: rtl/rst_clk_out_pkg.sv
package rst_clk_out_pkg;
  typedef enum logic [1:0] {
    CKSEL_FULL = 2'b00,
    CKSEL_DIV  = 2'b01,
    CKSEL_OFF  = 2'b10,
    CKSEL_OFF2 = 2'b11
  } ck_sel_e;

  localparam logic [7:0] SOFT_RST_CODE = 8'h08;
  localparam int CTRL_SYS_BIT = 7;
endpackage

// File: rtl/rcout_softrst.sv
module rcout_softrst
  import rst_clk_out_pkg::*;
#(
  parameter int PULSE_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_i,
  input  logic       irq_clr_i,
  output logic       pulse_o,
  output logic       irq_o
);
  logic [PULSE_W-1:0] cnt_q;
  logic               busy_q;
  logic               fire;

  assign fire = cmd_we_i && (cmd_i == SOFT_RST_CODE);

  // width is 2^PULSE_W: load all ones, run down to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fire) begin
      busy_q <= 1'b1;
      cnt_q  <= '1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_o <= 1'b0;
    else if (fire)      irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end

  assign pulse_o = busy_q;
endmodule

// File: rtl/rcout_mcu_regs.sv
module rcout_mcu_regs
  import rst_clk_out_pkg::*;
#(
  parameter int              ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h2E,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 7'h2F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_pol_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              sys_rel_o,
  output ck_sel_e           mck_sel_o,
  output ck_sel_e           mck2_sel_o,
  output logic              irq_clr_o
);
  logic cs_act;
  logic wr;
  logic unused_wdata;

  assign cs_act = cs_pol_i ? ~cs_i : cs_i;
  assign wr     = we_i && cs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_rel_o  <= 1'b1;
      mck_sel_o  <= CKSEL_FULL;
      mck2_sel_o <= CKSEL_FULL;
    end else if (wr && addr_i == CTRL_ADDR) begin
      sys_rel_o  <= wdata_i[CTRL_SYS_BIT];
      mck_sel_o  <= ck_sel_e'(wdata_i[1:0]);
      mck2_sel_o <= ck_sel_e'(wdata_i[3:2]);
    end
  end

  assign irq_clr_o    = wr && (addr_i == CLR_ADDR) && wdata_i[0];
  assign unused_wdata = ^wdata_i[6:4];
endmodule

// File: rtl/rcout_clk_out.sv
module rcout_clk_out
  import rst_clk_out_pkg::*;
#(
  parameter int DIV_W = 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ck_sel_e sel_i,
  output logic    ck_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             div_ck;
  ck_sel_e          eff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_ck = cnt_q[DIV_W-1];

  // at a falling edge with the divided clock low every source is low,
  // so switching here cannot cut a pulse short
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      eff_q <= CKSEL_FULL;
    else if (!div_ck) eff_q <= sel_i;
  end

  always_comb begin
    unique case (eff_q)
      CKSEL_FULL: ck_o = clk_i;
      CKSEL_DIV:  ck_o = div_ck;
      default:    ck_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rst_clk_out_ctrl.sv
module rst_clk_out_ctrl
  import rst_clk_out_pkg::*;
#(
  parameter int                PULSE_W    = 15,
  parameter int                ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 7'h2E,
  parameter logic [ADDR_W-1:0] CLR_ADDR   = 7'h2F,
  parameter int                MCK_DIV_W  = 1,
  parameter int                MCK2_DIV_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rst_ni,
  input  logic              host_cmd_we_i,
  input  logic [7:0]        host_cmd_i,
  input  logic              cs_pol_i,
  input  logic              mcu_cs_i,
  input  logic              mcu_we_i,
  input  logic [ADDR_W-1:0] mcu_addr_i,
  input  logic [7:0]        mcu_wdata_i,
  output logic              cpu_rst_oe_o,
  output logic              sys_rst_oe_o,
  output logic              mcu_irq_o,
  output logic              mck_o,
  output logic              mck2_o
);
  localparam int NUM_CK = 2;
  localparam int DIV_W_TAB [NUM_CK] = '{MCK_DIV_W, MCK2_DIV_W};

  logic    pulse;
  logic    irq_clr;
  logic    sys_rel;
  ck_sel_e ck_sel [NUM_CK];
  logic    ck_out [NUM_CK];

  rcout_mcu_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_pol_i   (cs_pol_i),
    .cs_i       (mcu_cs_i),
    .we_i       (mcu_we_i),
    .addr_i     (mcu_addr_i),
    .wdata_i    (mcu_wdata_i),
    .sys_rel_o  (sys_rel),
    .mck_sel_o  (ck_sel[0]),
    .mck2_sel_o (ck_sel[1]),
    .irq_clr_o  (irq_clr)
  );

  rcout_softrst #(.PULSE_W(PULSE_W)) u_softrst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (host_cmd_we_i),
    .cmd_i     (host_cmd_i),
    .irq_clr_i (irq_clr),
    .pulse_o   (pulse),
    .irq_o     (mcu_irq_o)
  );

  // open-drain enables: high means pull the pin low
  assign cpu_rst_oe_o = ~rst_ni | pulse;
  assign sys_rst_oe_o = ~sys_rel | ~host_rst_ni;

  for (genvar g = 0; g < NUM_CK; g++) begin : g_ck
    rcout_clk_out #(.DIV_W(DIV_W_TAB[g])) u_ck (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (ck_sel[g]),
      .ck_o   (ck_out[g])
    );
  end

  assign mck_o  = ck_out[0];
  assign mck2_o = ck_out[1];
endmodule

// File: rtl/rst_clk_out_chk.sv
module rst_clk_out_chk #(
  parameter int                PULSE_W   = 15,
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 7'h2F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rst_ni,
  input logic              host_cmd_we_i,
  input logic [7:0]        host_cmd_i,
  input logic              cs_pol_i,
  input logic              mcu_cs_i,
  input logic              mcu_we_i,
  input logic [ADDR_W-1:0] mcu_addr_i,
  input logic [7:0]        mcu_wdata_i,
  input logic              cpu_rst_oe_o,
  input logic              sys_rst_oe_o,
  input logic              mcu_irq_o
);
  localparam int          SW    = PULSE_W + 1;
  localparam logic [SW-1:0] PLEN = SW'(1) << PULSE_W;

  logic          cmd_hit;
  logic          clr_wr;
  logic [SW-1:0] since_q;

  assign cmd_hit = host_cmd_we_i && host_cmd_i == 8'h08;
  assign clr_wr  = mcu_we_i && (cs_pol_i != mcu_cs_i) &&
                   mcu_addr_i == CLR_ADDR && mcu_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_q <= '1;
    else if (cmd_hit)        since_q <= '0;
    else if (since_q != '1)  since_q <= since_q + 1'b1;
  end

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit |=> cpu_rst_oe_o);

  p_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_oe_o |-> since_q < PLEN);

  p_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_cmd_we_i && host_cmd_i != 8'h08 && !cpu_rst_oe_o) |=> !cpu_rst_oe_o);

  p_irq_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit |=> mcu_irq_o);

  p_irq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcu_irq_o && !clr_wr) |=> mcu_irq_o);

  p_host_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rst_ni |-> sys_rst_oe_o);

  always_comb begin
    if (rst_ni === 1'b0) p_chip_rst_r4: assert (cpu_rst_oe_o);
  end
endmodule

bind rst_clk_out_ctrl rst_clk_out_chk #(
  .PULSE_W(PULSE_W), .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_rst_ni   (host_rst_ni),
  .host_cmd_we_i (host_cmd_we_i),
  .host_cmd_i    (host_cmd_i),
  .cs_pol_i      (cs_pol_i),
  .mcu_cs_i      (mcu_cs_i),
  .mcu_we_i      (mcu_we_i),
  .mcu_addr_i    (mcu_addr_i),
  .mcu_wdata_i   (mcu_wdata_i),
  .cpu_rst_oe_o  (cpu_rst_oe_o),
  .sys_rst_oe_o  (sys_rst_oe_o),
  .mcu_irq_o     (mcu_irq_o)
);

// File: tb/rst_clk_out_ctrl_tb.sv
module rst_clk_out_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_W    = 4;
  localparam int PLEN       = 1 << PULSE_W;
  localparam logic [6:0] CTRL_A = 7'h2E;
  localparam logic [6:0] CLR_A  = 7'h2F;
  // {cs_pol, cs, bit7, host_rst_n, expected sys_rst_oe}
  localparam logic [4:0] VEC [8] = '{
    5'b1_0_0_1_1, 5'b1_1_0_1_0, 5'b0_1_0_1_1, 5'b0_0_0_1_0,
    5'b1_0_1_1_0, 5'b1_1_1_0_1, 5'b0_1_1_0_1, 5'b0_0_0_0_1
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_rst_ni = 1'b1;
  logic       host_cmd_we_i = 1'b0;
  logic [7:0] host_cmd_i = 8'h00;
  logic       cs_pol_i = 1'b1;
  logic       mcu_cs_i = 1'b1;
  logic       mcu_we_i = 1'b0;
  logic [6:0] mcu_addr_i = '0;
  logic [7:0] mcu_wdata_i = '0;
  logic       cpu_rst_oe_o, sys_rst_oe_o, mcu_irq_o, mck_o, mck2_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_clk_out_ctrl #(.PULSE_W(PULSE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .host_rst_ni(host_rst_ni),
    .host_cmd_we_i(host_cmd_we_i), .host_cmd_i(host_cmd_i),
    .cs_pol_i(cs_pol_i), .mcu_cs_i(mcu_cs_i), .mcu_we_i(mcu_we_i),
    .mcu_addr_i(mcu_addr_i), .mcu_wdata_i(mcu_wdata_i),
    .cpu_rst_oe_o(cpu_rst_oe_o), .sys_rst_oe_o(sys_rst_oe_o),
    .mcu_irq_o(mcu_irq_o), .mck_o(mck_o), .mck2_o(mck2_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mcu_wr(input logic pol, input logic cs, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_pol_i = pol; mcu_cs_i = cs; mcu_we_i = 1'b1; mcu_addr_i = a; mcu_wdata_i = d;
    @(negedge clk);
    mcu_we_i = 1'b0; cs_pol_i = 1'b1; mcu_cs_i = 1'b1;
  endtask

  task automatic host_cmd(input logic [7:0] c);
    @(negedge clk);
    host_cmd_we_i = 1'b1; host_cmd_i = c;
    @(negedge clk);
    host_cmd_we_i = 1'b0;
  endtask

  // counts negedge samples with cpu_rst_oe_o high, starting at the current one
  task automatic pulse_len(output int n);
    n = 0;
    while (cpu_rst_oe_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int hi;
    longint t_r;
    #1;
    check(cpu_rst_oe_o === 1'b1, "R4 in reset", cpu_rst_oe_o, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cpu_rst_oe_o === 1'b0, "R11 cpu_rst", cpu_rst_oe_o, 0);
    check(sys_rst_oe_o === 1'b0, "R11 sys_rst", sys_rst_oe_o, 0);
    check(mcu_irq_o === 1'b0, "R11 irq", mcu_irq_o, 0);
    check(mck_o === 1'b0 && mck2_o === 1'b0, "R11 clocks low phase", mck_o, 0);
    @(posedge clk); #1;
    check(mck_o === 1'b1 && mck2_o === 1'b1, "R11 clocks high phase", mck_o, 1);

    // R5 R6 vector table
    foreach (VEC[i]) begin
      mcu_wr(1'b1, 1'b0, CTRL_A, 8'h80);
      host_rst_ni = VEC[i][1];
      mcu_wr(VEC[i][4], VEC[i][3], CTRL_A, {VEC[i][2], 7'b0});
      check(sys_rst_oe_o === VEC[i][0], $sformatf("R5/R6 vec %0d", i), sys_rst_oe_o, VEC[i][0]);
    end
    host_rst_ni = 1'b1;
    mcu_wr(1'b1, 1'b0, CTRL_A, 8'h80);

    // R2 ignored codes
    host_cmd(8'h09);
    host_cmd(8'h00);
    hi = 0;
    repeat (20) begin
      if (cpu_rst_oe_o || mcu_irq_o) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R2 other code", hi, 0);

    // R1 pulse width, R3 set
    @(negedge clk);
    host_cmd_we_i = 1'b1; host_cmd_i = 8'h08;
    @(negedge clk);
    host_cmd_we_i = 1'b0;
    check(mcu_irq_o === 1'b1, "R3 irq set", mcu_irq_o, 1);
    pulse_len(n);
    check(n == PLEN, "R1 width", n, PLEN);

    // R3 hold: clear with inactive select ignored (R6), then real clear
    mcu_wr(1'b1, 1'b1, CLR_A, 8'h01);
    check(mcu_irq_o === 1'b1, "R3 R6 clear unselected", mcu_irq_o, 1);
    mcu_wr(1'b1, 1'b0, CLR_A, 8'h00);
    check(mcu_irq_o === 1'b1, "R3 clear bit0 zero", mcu_irq_o, 1);
    mcu_wr(1'b0, 1'b1, CLR_A, 8'h01);
    check(mcu_irq_o === 1'b0, "R3 clear", mcu_irq_o, 0);

    // R3 set wins over clear in same cycle
    @(negedge clk);
    host_cmd_we_i = 1'b1; host_cmd_i = 8'h08;
    mcu_we_i = 1'b1; cs_pol_i = 1'b1; mcu_cs_i = 1'b0; mcu_addr_i = CLR_A; mcu_wdata_i = 8'h01;
    @(negedge clk);
    host_cmd_we_i = 1'b0; mcu_we_i = 1'b0; mcu_cs_i = 1'b1;
    check(mcu_irq_o === 1'b1, "R3 set wins", mcu_irq_o, 1);
    pulse_len(n);
    mcu_wr(1'b1, 1'b0, CLR_A, 8'h01);

    // R10 retrigger
    host_cmd(8'h08);
    repeat (5) @(negedge clk);
    host_cmd(8'h08);
    pulse_len(n);
    check(n == PLEN, "R10 retrigger width", n, PLEN);

    // R4 async reset during pulse
    host_cmd(8'h08);
    repeat (3) @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 check(cpu_rst_oe_o === 1'b1, "R4 async", cpu_rst_oe_o, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cpu_rst_oe_o === 1'b0 && mcu_irq_o === 1'b0, "R4 pulse cancelled", cpu_rst_oe_o, 0);

    // R7 divided by 2
    mcu_wr(1'b1, 1'b0, CTRL_A, 8'h81);
    repeat (4) @(negedge clk);
    hi = 0; n = 0;
    begin
      logic prev;
      @(posedge clk); #1; prev = mck_o;
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); #1;
        if (mck_o === prev) n++;
        if (mck_o) hi++;
        prev = mck_o;
      end
    end
    check(n == 0 && hi == 4, "R7 div2", hi, 4);
    // R7 stopped
    mcu_wr(1'b1, 1'b0, CTRL_A, 8'h82);
    repeat (4) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1; if (mck_o !== 1'b0) hi++;
      @(negedge clk); #1; if (mck_o !== 1'b0) hi++;
    end
    check(hi == 0, "R7 stopped", hi, 0);
    // R8 full while mck stopped
    @(posedge clk); #1;
    check(mck2_o === 1'b1, "R8 full high", mck2_o, 1);
    @(negedge clk); #1;
    check(mck2_o === 1'b0, "R8 full low", mck2_o, 0);

    // R8 divided by 512, then R9 mid-high stop
    mcu_wr(1'b1, 1'b0, CTRL_A, 8'h84);
    n = 0;
    while (mck2_o !== 1'b0 && n < 2000) begin @(posedge clk); #1; n++; end
    while (mck2_o !== 1'b1 && n < 4000) begin @(posedge clk); #1; n++; end
    t_r = $time; hi = 0;
    while (mck2_o === 1'b1 && hi < 2000) begin @(posedge clk); #1; hi++; end
    check(hi == 256, "R8 div512 high", hi, 256);
    n = 0;
    while (mck2_o === 1'b0 && n < 2000) begin @(posedge clk); #1; n++; end
    check(n == 256, "R8 div512 low", n, 256);
    t_r = $time;
    repeat (10) @(posedge clk);
    mcu_wr(1'b1, 1'b0, CTRL_A, 8'h88);
    while (mck2_o === 1'b1 && ($time - t_r) < 5000) begin @(posedge clk); #1; end
    check(($time - t_r) / CLK_PERIOD == 256, "R9 no runt", int'(($time - t_r) / CLK_PERIOD), 256);
    hi = 0;
    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #1; if (mck2_o !== 1'b0) hi++;
    end
    check(hi == 0, "R9 stays stopped", hi, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule